// File: doc/BRIEF.md
# Multi-Slot Cipher Key Vault

The key vault keeps up to eight 128-bit key areas for a block cipher and hands one stored key to the cipher's working key register when asked. Keys arrive as a serial stream of 32-bit words over a write port, four words per area. A 128-bit key fills only the area it names. A 192-bit or 256-bit key fills an aligned pair of areas: (0,1), (2,3), (4,5) or (6,7). Naming either member of a pair selects the whole pair. The vault holds keys of a single length at any time. Starting a write with a different length drops every stored key.

A load request names one area. The vault checks that area against its valid map and its current length, then copies the key word by word into the cipher key register. It also reports the key length it copied. Every write, load or rejected request ends with a one-cycle completion pulse and a two-bit status: 0 means success, 1 means a store error and 2 means an invalid area. A separate pulse reports a request that arrived while the vault was busy. The written-area map can be read at all times, and writing a one to any bit of it permanently clears that area.

Top module: `key_vault`

## Requirements
- R1: After reset, busy_o, done_o and rej_o are 0, written_o is 0, cipher_key_o and cipher_len_o are 0, and key_len_o is 0 (the 128-bit code).
- R2: A write with length code 0 (128 bits) stores four words into the named area. Area n maps to written_o bit n. That bit goes high at the clock edge that accepts the fourth word, and at the same edge done_o rises with status 0.
- R3: With length code 1 (192 bits) or 2 (256 bits), the write fills the pair starting at the even area at or below the named one. Words 0 to 3 go to the even area and the remaining words go to the odd area: six words in total for code 1 and eight for code 2. For code 1 the last two words of the odd area are filled with zero. Both written_o bits are set when the final word is accepted.
- R4: When a write is accepted with a length code that differs from key_len_o, every written_o bit is cleared at that edge, and key_len_o takes the new code.
- R5: A load may name either member of a pair. On success, cipher_key_o holds key word k in bits [32k+31:32k], with the words above the key length equal to zero. cipher_len_o takes the stored length code. done_o rises with status 0 four clock cycles after the accepting edge for 128-bit keys, and eight cycles after it for longer keys.
- R6: A load that names an area without a valid key ends with status 2 on the cycle after acceptance, and cipher_key_o stays unchanged. For the longer lengths, a key counts as valid only if both areas of its pair are valid.
- R7: A cycle with inval_we_i high clears every written_o bit that is set in inval_mask_i. If a write commits on the same edge, the clear takes precedence.
- R8: Raising wr_abort_i during a write ends it with status 1. The targeted areas stay invalid, even if they held a key before the write.
- R9: busy_o is high from the edge that accepts a write or a valid load until the edge that completes it. A write or load request made while busy causes a one-cycle rej_o pulse and leaves the ongoing operation unaffected.
- R10: If a write request and a load request arrive together while the vault is idle, the write is accepted and the load is rejected through rej_o.
- R11: A write request with the reserved length code 3 ends with status 1 on the next cycle, with no change to written_o, key_len_o or busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_req_i | input | 1 | Start a key write |
| wr_area_i | input | 3 | Area named by the write |
| wr_len_i | input | 2 | Write length code: 0 = 128, 1 = 192, 2 = 256, 3 = reserved |
| wr_word_vld_i | input | 1 | A key word is present on wr_word_i |
| wr_word_i | input | 32 | Key word |
| wr_abort_i | input | 1 | Abort the write in progress |
| ld_req_i | input | 1 | Start a key load |
| ld_area_i | input | 3 | Area named by the load |
| inval_we_i | input | 1 | Write strobe for the written-area map |
| inval_mask_i | input | 8 | Ones select the areas to clear |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result code, valid while done_o is high |
| rej_o | output | 1 | One-cycle pulse for a refused request |
| written_o | output | 8 | Valid map, one bit per area |
| key_len_o | output | 2 | Length code of the keys currently stored |
| cipher_key_o | output | 256 | Cipher working key register |
| cipher_len_o | output | 2 | Length code of the loaded key |

## Verification
A corrupt valid map shows up as early as the next load of the affected area: the status flips between 0 and 2, and in the status-2 case the cipher key register keeps its old contents. A wrong word counter or wrong pair base does not show up at write time. It appears only when the key is loaded back, as words placed in the wrong positions of cipher_key_o or as a completion pulse arriving in the wrong cycle. That is why each stored key is read back and compared word for word, and why the load latency is counted. If the tracked length drifts, a later write fails to clear the other areas at acceptance, which can be seen on written_o in the cycle that follows.

// File: rtl/kv_pkg.sv
package kv_pkg;
  localparam int unsigned AREAS     = 8;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned WPA       = 4;
  localparam int unsigned AW        = $clog2(AREAS);
  localparam int unsigned WIX       = $clog2(WPA);
  localparam int unsigned IDX_W     = AW + WIX;
  localparam int unsigned KEY_WORDS = 2 * WPA;
  localparam int unsigned CNT_W     = $clog2(KEY_WORDS);
  localparam int unsigned KEY_W     = KEY_WORDS * WORD_W;

  typedef enum logic [1:0] {
    KL_128 = 2'd0,
    KL_192 = 2'd1,
    KL_256 = 2'd2,
    KL_RSV = 2'd3
  } klen_e;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_STORE_ERR = 2'd1,
    ST_BAD_AREA  = 2'd2
  } kst_e;

  function automatic logic is_long(input logic [1:0] l);
    return (l == KL_192) || (l == KL_256);
  endfunction

  function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a, input logic [1:0] l);
    return is_long(l) ? {a[AW-1:1], 1'b0} : a;
  endfunction

  function automatic logic [AREAS-1:0] span_mask(input logic [AW-1:0] a, input logic [1:0] l);
    logic [AREAS-1:0] m;
    logic [AW-1:0]    b;
    m = '0;
    b = base_of(a, l);
    m[b] = 1'b1;
    if (is_long(l)) m[{b[AW-1:1], 1'b1}] = 1'b1;
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] last_word(input logic [1:0] l);
    case (l)
      KL_192:  return CNT_W'(WPA + WPA / 2 - 1);
      KL_256:  return CNT_W'(2 * WPA - 1);
      default: return CNT_W'(WPA - 1);
    endcase
  endfunction
endpackage

// File: rtl/kv_key_ram.sv
module kv_key_ram
  import kv_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    widx_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic                zfill_i,
  input  logic [AW-1:0]       zarea_i,
  input  logic [IDX_W-1:0]    ridx_i,
  output logic [WORD_W-1:0]   rdata_o
);
  logic [WORD_W-1:0] mem [AREAS*WPA];

  for (genvar a = 0; a < AREAS; a++) begin : g_area
    for (genvar w = 0; w < WPA; w++) begin : g_word
      localparam int unsigned IDX   = a * WPA + w;
      localparam bit          UPPER = (w >= WPA / 2);
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (we_i && (widx_i == IDX_W'(IDX))) begin
          q <= wdata_i;
        end else if (UPPER && zfill_i && (zarea_i == AW'(a))) begin
          q <= '0;
        end
      end
      assign mem[IDX] = q;
    end
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/kv_valid_track.sv
module kv_valid_track
  import kv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       start_len_i,
  input  logic [AREAS-1:0] start_mask_i,
  input  logic             commit_i,
  input  logic [AREAS-1:0] commit_mask_i,
  input  logic             inval_i,
  input  logic [AREAS-1:0] inval_mask_i,
  output logic [AREAS-1:0] valid_o,
  output logic [1:0]       cur_len_o
);
  logic [AREAS-1:0] valid_q, valid_d;
  logic [1:0]       len_q;

  always_comb begin
    valid_d = valid_q;
    if (start_i) begin
      // a length change drops the whole store
      if (start_len_i != len_q) valid_d = '0;
      else                      valid_d = valid_q & ~start_mask_i;
    end
    if (commit_i) valid_d = valid_d | commit_mask_i;
    if (inval_i)  valid_d = valid_d & ~inval_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      len_q   <= KL_128;
    end else begin
      valid_q <= valid_d;
      if (start_i) len_q <= start_len_i;
    end
  end

  assign valid_o   = valid_q;
  assign cur_len_o = len_q;
endmodule

// File: rtl/kv_seq.sv
module kv_seq
  import kv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_req_i,
  input  logic [AW-1:0]      wr_area_i,
  input  logic [1:0]         wr_len_i,
  input  logic               wr_word_vld_i,
  input  logic [WORD_W-1:0]  wr_word_i,
  input  logic               wr_abort_i,
  input  logic               ld_req_i,
  input  logic [AW-1:0]      ld_area_i,
  input  logic [AREAS-1:0]   valid_i,
  input  logic [1:0]         cur_len_i,
  output logic               start_o,
  output logic [1:0]         start_len_o,
  output logic [AREAS-1:0]   start_mask_o,
  output logic               commit_o,
  output logic [AREAS-1:0]   commit_mask_o,
  output logic               ram_we_o,
  output logic [IDX_W-1:0]   ram_idx_o,
  output logic [WORD_W-1:0]  ram_wdata_o,
  output logic               ram_zfill_o,
  output logic [AW-1:0]      ram_zarea_o,
  input  logic [WORD_W-1:0]  ram_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         status_o,
  output logic               rej_o,
  output logic [KEY_W-1:0]   ckey_o,
  output logic [1:0]         clen_o
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_LD} st_e;

  st_e                               st_q;
  logic [CNT_W-1:0]                  cnt_q, last_q;
  logic [AW-1:0]                     base_q;
  logic [1:0]                        len_q;
  logic                              done_q, rej_q;
  kst_e                              status_q;
  logic [KEY_WORDS-1:0][WORD_W-1:0]  ckey_q;
  logic [1:0]                        clen_q;

  logic          idle, wr_ok, ld_ok, word_take;
  logic [AW-1:0] ld_base;

  assign idle    = (st_q == S_IDLE);
  assign wr_ok   = wr_len_i != KL_RSV;
  assign ld_base = base_of(ld_area_i, cur_len_i);
  assign ld_ok   = is_long(cur_len_i) ? (valid_i[ld_base] & valid_i[{ld_base[AW-1:1], 1'b1}])
                                      : valid_i[ld_area_i];

  assign start_o      = idle && wr_req_i && wr_ok;
  assign start_len_o  = wr_len_i;
  assign start_mask_o = span_mask(wr_area_i, wr_len_i);

  assign word_take     = (st_q == S_WR) && !wr_abort_i && wr_word_vld_i;
  assign commit_o      = word_take && (cnt_q == last_q);
  assign commit_mask_o = span_mask(base_q, len_q);

  // even area for words 0..WPA-1, odd partner after that
  assign ram_idx_o   = {base_q[AW-1:1], base_q[0] | cnt_q[CNT_W-1], cnt_q[WIX-1:0]};
  assign ram_we_o    = word_take;
  assign ram_wdata_o = wr_word_i;
  assign ram_zfill_o = commit_o && (len_q == KL_192);
  assign ram_zarea_o = {base_q[AW-1:1], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      last_q   <= '0;
      base_q   <= '0;
      len_q    <= KL_128;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
      status_q <= ST_OK;
      ckey_q   <= '0;
      clen_q   <= KL_128;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (wr_req_i) begin
            rej_q <= ld_req_i;
            if (!wr_ok) begin
              done_q   <= 1'b1;
              status_q <= ST_STORE_ERR;
            end else begin
              st_q   <= S_WR;
              cnt_q  <= '0;
              base_q <= base_of(wr_area_i, wr_len_i);
              len_q  <= wr_len_i;
              last_q <= last_word(wr_len_i);
            end
          end else if (ld_req_i) begin
            if (!ld_ok) begin
              done_q   <= 1'b1;
              status_q <= ST_BAD_AREA;
            end else begin
              st_q   <= S_LD;
              cnt_q  <= '0;
              base_q <= ld_base;
              last_q <= is_long(cur_len_i) ? CNT_W'(KEY_WORDS - 1) : CNT_W'(WPA - 1);
              clen_q <= cur_len_i;
              if (!is_long(cur_len_i)) begin
                for (int k = WPA; k < KEY_WORDS; k++) ckey_q[k] <= '0;
              end
            end
          end
        end
        S_WR: begin
          rej_q <= wr_req_i | ld_req_i;
          if (wr_abort_i) begin
            done_q   <= 1'b1;
            status_q <= ST_STORE_ERR;
            st_q     <= S_IDLE;
          end else if (wr_word_vld_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == last_q) begin
              done_q   <= 1'b1;
              status_q <= ST_OK;
              st_q     <= S_IDLE;
            end
          end
        end
        S_LD: begin
          rej_q         <= wr_req_i | ld_req_i;
          ckey_q[cnt_q] <= ram_rdata_i;
          cnt_q         <= cnt_q + 1'b1;
          if (cnt_q == last_q) begin
            done_q   <= 1'b1;
            status_q <= ST_OK;
            st_q     <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = !idle;
  assign done_o   = done_q;
  assign status_o = status_q;
  assign rej_o    = rej_q;
  assign ckey_o   = ckey_q;
  assign clen_o   = clen_q;
endmodule

// File: rtl/key_vault.sv
module key_vault
  import kv_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_req_i,
  input  logic [AW-1:0]       wr_area_i,
  input  logic [1:0]          wr_len_i,
  input  logic                wr_word_vld_i,
  input  logic [WORD_W-1:0]   wr_word_i,
  input  logic                wr_abort_i,
  input  logic                ld_req_i,
  input  logic [AW-1:0]       ld_area_i,
  input  logic                inval_we_i,
  input  logic [AREAS-1:0]    inval_mask_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          status_o,
  output logic                rej_o,
  output logic [AREAS-1:0]    written_o,
  output logic [1:0]          key_len_o,
  output logic [KEY_W-1:0]    cipher_key_o,
  output logic [1:0]          cipher_len_o
);
  logic               start, commit, ram_we, ram_zfill;
  logic [1:0]         start_len, cur_len;
  logic [AREAS-1:0]   start_mask, commit_mask, valid;
  logic [IDX_W-1:0]   ram_idx;
  logic [WORD_W-1:0]  ram_wdata, ram_rdata;
  logic [AW-1:0]      ram_zarea;

  kv_seq u_seq (
    .clk_i, .rst_ni,
    .wr_req_i, .wr_area_i, .wr_len_i, .wr_word_vld_i, .wr_word_i, .wr_abort_i,
    .ld_req_i, .ld_area_i,
    .valid_i       (valid),
    .cur_len_i     (cur_len),
    .start_o       (start),
    .start_len_o   (start_len),
    .start_mask_o  (start_mask),
    .commit_o      (commit),
    .commit_mask_o (commit_mask),
    .ram_we_o      (ram_we),
    .ram_idx_o     (ram_idx),
    .ram_wdata_o   (ram_wdata),
    .ram_zfill_o   (ram_zfill),
    .ram_zarea_o   (ram_zarea),
    .ram_rdata_i   (ram_rdata),
    .busy_o, .done_o, .status_o, .rej_o,
    .ckey_o        (cipher_key_o),
    .clen_o        (cipher_len_o)
  );

  kv_valid_track u_track (
    .clk_i, .rst_ni,
    .start_i       (start),
    .start_len_i   (start_len),
    .start_mask_i  (start_mask),
    .commit_i      (commit),
    .commit_mask_i (commit_mask),
    .inval_i       (inval_we_i),
    .inval_mask_i  (inval_mask_i),
    .valid_o       (valid),
    .cur_len_o     (cur_len)
  );

  kv_key_ram u_ram (
    .clk_i, .rst_ni,
    .we_i    (ram_we),
    .widx_i  (ram_idx),
    .wdata_i (ram_wdata),
    .zfill_i (ram_zfill),
    .zarea_i (ram_zarea),
    .ridx_i  (ram_idx),
    .rdata_o (ram_rdata)
  );

  assign written_o = valid;
  assign key_len_o = cur_len;
endmodule

// File: rtl/key_vault_chk.sv
module key_vault_chk
  import kv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_req_i,
  input logic             ld_req_i,
  input logic             inval_we_i,
  input logic [AREAS-1:0] inval_mask_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [1:0]       status_o,
  input logic             rej_o,
  input logic [AREAS-1:0] written_o,
  input logic [KEY_W-1:0] cipher_key_o
);
  AST_NEW_AREA_ONLY_AT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((written_o & ~$past(written_o)) != '0) |-> (done_o && status_o == 2'd0)); // R2

  AST_BAD_AREA_KEEPS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd2) |-> $stable(cipher_key_o)); // R6

  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_we_i |=> ((written_o & $past(inval_mask_i)) == '0)); // R7

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R9

  AST_REJ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |-> ($past(busy_o) || $past(wr_req_i && ld_req_i))); // R10

  AST_STATUS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o != 2'd3)); // R11
endmodule

bind key_vault key_vault_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_req_i     (wr_req_i),
  .ld_req_i     (ld_req_i),
  .inval_we_i   (inval_we_i),
  .inval_mask_i (inval_mask_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .status_o     (status_o),
  .rej_o        (rej_o),
  .written_o    (written_o),
  .cipher_key_o (cipher_key_o)
);

// File: tb/key_vault_tb_top.sv
module key_vault_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_req_i = 1'b0;
  logic [2:0]   wr_area_i = '0;
  logic [1:0]   wr_len_i = '0;
  logic         wr_word_vld_i = 1'b0;
  logic [31:0]  wr_word_i = '0;
  logic         wr_abort_i = 1'b0;
  logic         ld_req_i = 1'b0;
  logic [2:0]   ld_area_i = '0;
  logic         inval_we_i = 1'b0;
  logic [7:0]   inval_mask_i = '0;
  logic         busy_o, done_o, rej_o;
  logic [1:0]   status_o, key_len_o, cipher_len_o;
  logic [7:0]   written_o;
  logic [255:0] cipher_key_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  key_vault dut_i (
    .clk_i, .rst_ni, .wr_req_i, .wr_area_i, .wr_len_i, .wr_word_vld_i, .wr_word_i,
    .wr_abort_i, .ld_req_i, .ld_area_i, .inval_we_i, .inval_mask_i,
    .busy_o, .done_o, .status_o, .rej_o, .written_o, .key_len_o,
    .cipher_key_o, .cipher_len_o
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] area;
    logic [1:0] len;
    logic [7:0] seed;
    logic [1:0] est;
    logic [7:0] ewr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{1'b1, 3'd3, 2'd0, 8'd11, 2'd0, 8'h08},
    '{1'b1, 3'd6, 2'd0, 8'd12, 2'd0, 8'h48},
    '{1'b0, 3'd3, 2'd0, 8'd11, 2'd0, 8'h48},
    '{1'b0, 3'd6, 2'd0, 8'd12, 2'd0, 8'h48},
    '{1'b0, 3'd2, 2'd0, 8'd0,  2'd2, 8'h48},
    '{1'b1, 3'd5, 2'd2, 8'd21, 2'd0, 8'h30},
    '{1'b0, 3'd4, 2'd2, 8'd21, 2'd0, 8'h30},
    '{1'b0, 3'd3, 2'd2, 8'd0,  2'd2, 8'h30},
    '{1'b1, 3'd0, 2'd2, 8'd22, 2'd0, 8'h33},
    '{1'b0, 3'd1, 2'd2, 8'd22, 2'd0, 8'h33},
    '{1'b1, 3'd7, 2'd1, 8'd31, 2'd0, 8'hC0},
    '{1'b0, 3'd6, 2'd1, 8'd31, 2'd0, 8'hC0},
    '{1'b0, 3'd5, 2'd1, 8'd0,  2'd2, 8'hC0},
    '{1'b1, 3'd2, 2'd0, 8'd41, 2'd0, 8'h04},
    '{1'b0, 3'd2, 2'd0, 8'd41, 2'd0, 8'h04}
  };

  function automatic logic [31:0] kw(input int s, input int k);
    return {8'(s), 8'(k), 8'(s * 7 + k), 8'hA5};
  endfunction

  function automatic int nw(input logic [1:0] l);
    return (l == 2'd0) ? 4 : (l == 2'd1) ? 6 : 8;
  endfunction

  function automatic logic [255:0] exp_key(input int s, input logic [1:0] l);
    logic [255:0] e;
    e = '0;
    for (int k = 0; k < 8; k++) if (k < nw(l)) e[k*32 +: 32] = kw(s, k);
    return e;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic accept_wr(input logic [2:0] a, input logic [1:0] l);
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_area_i = a; wr_len_i = l;
    @(negedge clk_i);
    wr_req_i = 1'b0;
  endtask

  // feeds n words; optional abort after them; optional clear on the last word
  task automatic feed(input int s, input int n, input bit abort, input logic [7:0] clr);
    for (int k = 0; k < n; k++) begin
      wr_word_vld_i = 1'b1; wr_word_i = kw(s, k);
      if (k == n - 1 && clr != 0) begin inval_we_i = 1'b1; inval_mask_i = clr; end
      @(negedge clk_i);
    end
    wr_word_vld_i = 1'b0; inval_we_i = 1'b0; inval_mask_i = '0;
    if (abort) begin
      wr_abort_i = 1'b1;
      @(negedge clk_i);
      wr_abort_i = 1'b0;
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 20) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic do_load(input logic [2:0] a, output int cyc);
    @(negedge clk_i);
    ld_req_i = 1'b1; ld_area_i = a;
    @(negedge clk_i);
    ld_req_i = 1'b0;
    wait_done(cyc);
  endtask

  task automatic inval(input logic [7:0] m);
    @(negedge clk_i);
    inval_we_i = 1'b1; inval_mask_i = m;
    @(negedge clk_i);
    inval_we_i = 1'b0; inval_mask_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] last_key;
    int cyc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", 256'(busy_o), 0);
    chk("R1 done", 256'(done_o), 0);
    chk("R1 rej", 256'(rej_o), 0);
    chk("R1 written", 256'(written_o), 0);
    chk("R1 key", cipher_key_o, 0);
    chk("R1 len", 256'({key_len_o, cipher_len_o}), 0);
    last_key = '0;

    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) begin
        accept_wr(VT[i].area, VT[i].len);
        feed(VT[i].seed, nw(VT[i].len), 1'b0, 8'h00);
        chk(VT[i].len == 0 ? "R2 done" : "R3 done", 256'(done_o), 1);
        chk(VT[i].len == 0 ? "R2 status" : "R3 status", 256'(status_o), 0);
        chk("R4 written", 256'(written_o), 256'(VT[i].ewr));
        chk("R4 key_len", 256'(key_len_o), 256'(VT[i].len));
      end else begin
        do_load(VT[i].area, cyc);
        chk("R5/R6 status", 256'(status_o), 256'(VT[i].est));
        if (VT[i].est == 0) begin
          last_key = exp_key(VT[i].seed, VT[i].len);
          chk("R5 key", cipher_key_o, last_key);
          chk("R5 latency", 256'(cyc), 256'(VT[i].len == 0 ? 4 : 8));
          chk("R5 cipher_len", 256'(cipher_len_o), 256'(VT[i].len));
        end else begin
          chk("R6 key kept", cipher_key_o, last_key);
          chk("R6 latency", 256'(cyc), 0);
        end
        chk("R5 written", 256'(written_o), 256'(VT[i].ewr));
      end
    end

    // R7 clear through the written-area map
    inval(8'h04);
    chk("R7 cleared", 256'(written_o), 0);
    do_load(3'd2, cyc);
    chk("R7 load after clear", 256'(status_o), 2);

    // R7 clear on the commit edge wins
    accept_wr(3'd1, 2'd0);
    feed(50, 4, 1'b0, 8'h02);
    chk("R7 commit status", 256'(status_o), 0);
    chk("R7 same-edge clear", 256'(written_o), 0);

    // R8 abort over a previously valid area
    accept_wr(3'd0, 2'd0);
    feed(61, 4, 1'b0, 8'h00);
    chk("R8 pre-valid", 256'(written_o), 256'(8'h01));
    accept_wr(3'd0, 2'd0);
    feed(60, 2, 1'b1, 8'h00);
    chk("R8 done", 256'(done_o), 1);
    chk("R8 status", 256'(status_o), 1);
    chk("R8 written", 256'(written_o), 0);
    do_load(3'd0, cyc);
    chk("R8 load", 256'(status_o), 2);

    // R9 reject while loading
    accept_wr(3'd4, 2'd0);
    feed(70, 4, 1'b0, 8'h00);
    @(negedge clk_i);
    ld_req_i = 1'b1; ld_area_i = 3'd4;
    @(negedge clk_i);
    ld_req_i = 1'b0;
    chk("R9 busy", 256'(busy_o), 1);
    wr_req_i = 1'b1; wr_area_i = 3'd6; wr_len_i = 2'd0;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    chk("R9 rej", 256'(rej_o), 1);
    wait_done(cyc);
    chk("R9 status", 256'(status_o), 0);
    chk("R9 key", cipher_key_o, exp_key(70, 2'd0));
    chk("R9 idle", 256'(busy_o), 0);
    chk("R9 written", 256'(written_o), 256'(8'h10));

    // R10 simultaneous requests while idle
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_area_i = 3'd5; wr_len_i = 2'd0;
    ld_req_i = 1'b1; ld_area_i = 3'd4;
    @(negedge clk_i);
    wr_req_i = 1'b0; ld_req_i = 1'b0;
    chk("R10 rej", 256'(rej_o), 1);
    chk("R10 write taken", 256'(busy_o), 1);
    feed(71, 4, 1'b0, 8'h00);
    chk("R10 status", 256'(status_o), 0);
    chk("R10 written", 256'(written_o), 256'(8'h30));

    // R11 reserved length code
    accept_wr(3'd2, 2'd3);
    chk("R11 done", 256'(done_o), 1);
    chk("R11 status", 256'(status_o), 1);
    chk("R11 busy", 256'(busy_o), 0);
    chk("R11 written", 256'(written_o), 256'(8'h30));
    chk("R11 key_len", 256'(key_len_o), 0);

    // R4 drop at acceptance, R3 pair partly cleared
    accept_wr(3'd3, 2'd2);
    chk("R4 drop on accept", 256'(written_o), 0);
    feed(80, 8, 1'b0, 8'h00);
    chk("R3 pair", 256'(written_o), 256'(8'h0C));
    inval(8'h04);
    do_load(3'd3, cyc);
    chk("R6 half pair", 256'(status_o), 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule